// File: doc/BRIEF.md
# Mixed-Depth Pixel Selector

This block is a streaming pixel stage for a framebuffer that stores three planes side by side for every pixel: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. Each pixel makes its own choice. When the top byte of its control word holds the direct tag, the block takes the pixel's colour from the direct word. Otherwise the pixel's index is sent to an external palette memory and the colour that memory returns is used. The result is one 24-bit colour per pixel. A static order input chooses whether that colour is packed red-first or blue-first.

Input and output are valid/ready streams. A pixel triple moves in on a cycle where `in_valid` and `in_ready` are both high. A colour moves out on a cycle where `out_valid` and `out_ready` are both high. The palette is a synchronous read port: the block raises `pal_rd_en` with an index, and the colour for that index is on `pal_rd_rgb` one cycle later. The palette holds that value until the next read. The direct path goes through one register stage, the same depth as the palette read, so both kinds of pixel leave in the order they arrived. When `out_ready` is low the whole pipe stalls, the palette is not read, and nothing is lost or repeated.

Top module: `pix_mix_sel`

## Requirements
- R1: A pixel is direct when `in_ctrl[31:24]` equals 8'h03. Bits 23:0 of the control word never affect the choice.
- R2: Any other value of `in_ctrl[31:24]` selects palette colour. The block drives `pal_rd_idx` with `in_index`, and the palette returns {red, green, blue} on `pal_rd_rgb`, red in bits 23:16, one cycle after `pal_rd_en`.
- R3: For a direct pixel, bits 31:24 of `in_direct` are ignored. Bits 23:16 are blue, bits 15:8 are green and bits 7:0 are red.
- R4: With `in_bgr`=0 the output is packed red, green, blue, with red in bits 23:16. With `in_bgr`=1 it is packed blue, green, red. `in_bgr` is captured with each accepted pixel.
- R5: A pixel accepted on one clock edge is shown with `out_valid` high from that edge on.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_rgb` does not change and `in_ready` is low.
- R7: Every accepted pixel leaves exactly once, in the order it arrived. `in_ready` is high whenever the output register is empty or is being drained.
- R8: `pal_rd_en` is high exactly on cycles where a pixel is accepted, and never while the output is stalled.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel triple valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_index | input | 8 | Indexed-plane value |
| in_direct | input | 32 | Direct-colour plane word |
| in_ctrl | input | 32 | Control plane word (tag in the top byte) |
| in_bgr | input | 1 | Output packing: 0 red-first, 1 blue-first |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_rd_idx | output | 8 | Palette read address |
| pal_rd_rgb | input | 24 | Palette colour, one cycle after the read strobe |
| out_valid | output | 1 | Output colour valid |
| out_ready | input | 1 | Downstream accepts the colour |
| out_rgb | output | 24 | Packed output colour |

## Verification
The bench builds the block with its default parameters: an 8-bit index, 8-bit channels and direct tag 8'h03. With these settings every one of the 256 palette entries can be addressed. The tests cover tag values next to 8'h03 and control words whose lower bytes hold 8'h03, which must not count as the tag. The bench's palette model holds its read data across stalls, as a real synchronous memory would. Because of this, a pseudo-random `out_ready` pattern exposes any pixel dropped, repeated or reordered while palette and direct pixels are interleaved.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int PMS_CH_W = 8;
  localparam int PMS_NCH  = 3;
  localparam int PMS_RGB_W = PMS_CH_W * PMS_NCH;

  typedef struct packed {
    logic [PMS_CH_W-1:0] red;
    logic [PMS_CH_W-1:0] grn;
    logic [PMS_CH_W-1:0] blu;
  } pms_rgb_t;
endpackage

// File: rtl/pms_classify.sv
module pms_classify
  import pms_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int TAG_W = 8,
  parameter logic [TAG_W-1:0] TAG_DIRECT = 8'h03
) (
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic [WORD_W-1:0] direct_word,
  output logic              is_direct,
  output pms_rgb_t          direct_rgb
);
  localparam int TAG_LSB = WORD_W - TAG_W;

  assign is_direct = (ctrl_word[WORD_W-1:TAG_LSB] == TAG_DIRECT);

  // Direct word layout below the ignored top byte: blue, green, red.
  always_comb begin
    direct_rgb.blu = direct_word[3*PMS_CH_W-1:2*PMS_CH_W];
    direct_rgb.grn = direct_word[2*PMS_CH_W-1:PMS_CH_W];
    direct_rgb.red = direct_word[PMS_CH_W-1:0];
  end
endmodule

// File: rtl/pms_stage.sv
module pms_stage
  import pms_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     d_valid,
  input  logic     d_direct,
  input  logic     d_bgr,
  input  pms_rgb_t d_rgb,
  output logic     q_valid,
  output logic     q_direct,
  output logic     q_bgr,
  output pms_rgb_t q_rgb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else if (load) begin
      q_valid <= d_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_direct <= d_direct;
      q_bgr    <= d_bgr;
      q_rgb    <= d_rgb;
    end
  end
endmodule

// File: rtl/pms_pack.sv
module pms_pack
  import pms_pkg::*;
(
  input  pms_rgb_t               color,
  input  logic                   bgr,
  output logic [PMS_RGB_W-1:0]   packed_rgb
);
  logic [PMS_NCH-1:0][PMS_CH_W-1:0] chan;
  assign chan = color;

  for (genvar g = 0; g < PMS_NCH; g++) begin : g_slot
    assign packed_rgb[g*PMS_CH_W +: PMS_CH_W] = bgr ? chan[PMS_NCH-1-g] : chan[g];
  end
endmodule

// File: rtl/pix_mix_sel.sv
module pix_mix_sel
  import pms_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int WORD_W = 32,
  parameter int TAG_W = 8,
  parameter logic [TAG_W-1:0] TAG_DIRECT = 8'h03
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IDX_W-1:0]     in_index,
  input  logic [WORD_W-1:0]    in_direct,
  input  logic [WORD_W-1:0]    in_ctrl,
  input  logic                 in_bgr,
  output logic                 pal_rd_en,
  output logic [IDX_W-1:0]     pal_rd_idx,
  input  logic [PMS_RGB_W-1:0] pal_rd_rgb,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PMS_RGB_W-1:0] out_rgb
);
  logic     advance;
  logic     c_direct;
  pms_rgb_t c_rgb;
  logic     s_valid, s_direct, s_bgr;
  pms_rgb_t s_rgb;
  pms_rgb_t pick;

  assign advance    = !s_valid || out_ready;
  assign in_ready   = advance;
  assign pal_rd_en  = in_valid && advance;
  assign pal_rd_idx = in_index;

  pms_classify #(.WORD_W(WORD_W), .TAG_W(TAG_W), .TAG_DIRECT(TAG_DIRECT)) classify_i (
    .ctrl_word(in_ctrl), .direct_word(in_direct),
    .is_direct(c_direct), .direct_rgb(c_rgb)
  );

  pms_stage stage_i (
    .clk(clk), .rst_n(rst_n), .load(advance),
    .d_valid(in_valid), .d_direct(c_direct), .d_bgr(in_bgr), .d_rgb(c_rgb),
    .q_valid(s_valid), .q_direct(s_direct), .q_bgr(s_bgr), .q_rgb(s_rgb)
  );

  assign pick      = s_direct ? s_rgb : pms_rgb_t'(pal_rd_rgb);
  assign out_valid = s_valid;

  pms_pack pack_i (.color(pick), .bgr(s_bgr), .packed_rgb(out_rgb));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_no_read_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !pal_rd_en);

  assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_ctrl[WORD_W-1 -: TAG_W] == TAG_DIRECT && !in_bgr
    |=> out_rgb == {$past(in_direct[7:0]), $past(in_direct[15:8]), $past(in_direct[23:16])});

  assert_palette_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_ctrl[WORD_W-1 -: TAG_W] != TAG_DIRECT && !in_bgr
    |=> out_rgb == pal_rd_rgb);
endmodule

// File: tb/pix_mix_sel_tb.sv
`timescale 1ns/1ps
module pix_mix_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_index = '0;
  logic [31:0] in_direct = '0;
  logic [31:0] in_ctrl = '0;
  logic        in_bgr = 1'b0;
  logic        pal_rd_en;
  logic [7:0]  pal_rd_idx;
  logic [23:0] pal_rd_rgb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_rgb;

  int checks = 0;
  int fails = 0;
  int sent = 0;
  int rcvd = 0;
  bit ready_rand = 1'b0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [23:0] exp_q[$];
  bit prev_stall = 1'b0;
  logic [23:0] prev_rgb = '0;

  always #2 clk = ~clk;

  pix_mix_sel dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl), .in_bgr(in_bgr),
    .pal_rd_en(pal_rd_en), .pal_rd_idx(pal_rd_idx), .pal_rd_rgb(pal_rd_rgb),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
  );

  function automatic logic [23:0] pal_f(input logic [7:0] i);
    return {i, i ^ 8'hA5, ~i};
  endfunction

  always @(posedge clk) if (pal_rd_en) pal_rd_rgb <= pal_f(pal_rd_idx);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_of(input logic [7:0] idx, input logic [31:0] dir,
                                            input logic [31:0] ctl, input bit bgr);
    logic [7:0] r, g, b;
    if (ctl[31:24] == 8'h03) begin
      b = dir[23:16]; g = dir[15:8]; r = dir[7:0];
    end else begin
      {r, g, b} = pal_f(idx);
    end
    return bgr ? {b, g, r} : {r, g, b};
  endfunction

  task automatic send(input logic [7:0] idx, input logic [31:0] dir,
                      input logic [31:0] ctl, input bit bgr);
    @(negedge clk);
    in_valid = 1'b1; in_index = idx; in_direct = dir; in_ctrl = ctl; in_bgr = bgr;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back(expect_of(idx, dir, ctl, bgr));
    sent++;
    @(posedge clk);
    @(negedge clk); #1;
    chk(out_valid === 1'b1, "R5", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b0;
  endtask

  // Monitor: scoreboard compare, stall stability and palette strobe checks.
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = ready_rand ? lfsr[0] | lfsr[3] : 1'b1;
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          chk(out_valid === 1'b1 && out_rgb === prev_rgb, "R6", {8'd0, out_rgb}, {8'd0, prev_rgb});
        end
        if (out_valid && !out_ready) begin
          chk(!in_ready && !pal_rd_en, "R6/R8 stall", {30'd0, in_ready, pal_rd_en}, 32'd0);
        end
        chk(pal_rd_en === (in_valid && in_ready), "R8", {31'd0, pal_rd_en}, {31'd0, in_valid && in_ready});
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 extra output", {8'd0, out_rgb}, 32'd0);
          end else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            chk(out_rgb === e, "R1/R2/R3/R4 colour", {8'd0, out_rgb}, {8'd0, e});
          end
          rcvd++;
        end
        prev_stall = out_valid && !out_ready;
        prev_rgb = out_rgb;
      end
    end
  end

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9", {30'd0, out_valid, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9", {30'd0, out_valid, in_ready}, 32'd1);
    // R1/R3: direct tag; top byte of direct word ignored
    send(8'h10, 32'hFF_112233, 32'h03_000000, 1'b0);
    send(8'h10, 32'h00_112233, 32'h03_FFFFFF, 1'b0);
    // R2: tag neighbours and low bytes holding 03 select palette
    send(8'h20, 32'h00_445566, 32'h02_000000, 1'b0);
    send(8'h21, 32'h00_445566, 32'h04_000000, 1'b0);
    send(8'h22, 32'h00_445566, 32'h83_000000, 1'b0);
    send(8'h23, 32'h00_445566, 32'h00_000003, 1'b0);
    send(8'h00, 32'h0, 32'h0, 1'b0);
    send(8'hFF, 32'h0, 32'hFF_000000, 1'b0);
    // R4: blue-first packing on both paths
    send(8'h5A, 32'h00_ABCDEF, 32'h03_000000, 1'b1);
    send(8'h5A, 32'h00_ABCDEF, 32'h01_000000, 1'b1);
    // R7: pseudo-random back-pressure, mixed pixels
    ready_rand = 1'b1;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ctl;
      ctl = {(lfsr[5] ? 8'h03 : lfsr[15:8]), lfsr[7:0], lfsr[15:0]};
      send(lfsr[7:0] ^ k[7:0], {lfsr, lfsr ^ k[15:0]}, ctl, lfsr[2]);
    end
    ready_rand = 1'b0;
    repeat (10) @(negedge clk);
    chk(rcvd == sent && exp_q.size() == 0, "R7 count", rcvd, sent);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule